// File: doc/BRIEF.md
# Serial Port Sample Rate Generator

This block derives a divided bit clock and a periodic frame-sync pulse for the transmit and receive halves of a serial port. The source for the divider can be an internal peripheral clock or one of two external clock pins. All three arrive as levels and are sampled in the single system clock domain. Each source runs through a two-stage synchronizer, and a rising-edge detector turns each synchronized rising edge into a one-cycle source tick. All counting is done in source ticks.

Software programs the divider, the frame period and the frame width through a write strobe. The new values take effect only after two ticks of the selected source. A generator enable and a frame-sync enable start the outputs. When the generator is disabled, its output depends on how it got there. After a device reset, and until the first enable, the bit clock toggles at half the system clock. Once software has enabled the generator and then cleared the enable, both outputs stay low. A ready flag goes high once the bit clock has settled.

Top module: `srg_top`

## Requirements
- R1: The source code `cfg_src` selects the input: 2'b01 is `periph_clk`, 2'b10 is `rx_clk_pin` and 2'b11 is `tx_clk_pin`. Code 2'b00 is reserved. While it is selected with the generator enabled, `clkg` and `fsg` are low one cycle later. `src_err` is high in the cycle after a cycle with code 2'b00, and low after any other code.
- R2: From device reset until `gen_en` is first seen high, `clkg` inverts on every system clock while `gen_en` is low, and `fsg` stays low.
- R3: Once `gen_en` has been high, clearing it drives `clkg`, `fsg` and `ready` low from the next cycle on.
- R4: A `cfg_wr` pulse captures `cfg_div`, `cfg_fper` and `cfg_fwid`. The captured values become active on the second selected-source tick after the write. A new write restarts that count.
- R5: Each source passes through two synchronizer flops before edge detection. After enable, `clkg` goes high three system clocks after the first rising source edge and then keeps running.
- R6: `clkg` has a period of `cfg_div`+1 source ticks. It is high for ceil((div+1)/2) ticks and low for the rest. With a divider of 0, `clkg` follows the synchronized source level.
- R7: `ready` rises together with the third rising edge of `clkg` after enable, which is two full periods after the start. It drops when the generator is disabled or the source code is reserved.
- R8: With `fs_en` high and the clock running, `fsg` rises together with the (fper+1)-th rising edge of `clkg` that is counted after `fs_en`. It then repeats every fper+1 `clkg` periods. Dropping `fs_en` clears `fsg` on the next cycle.
- R9: `fsg` stays high for fwid+1 `clkg` periods. The width is clamped to fper, so the pulse falls before the next period begins. With a frame period of 0, `fsg` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low device reset |
| periph_clk | input | 1 | Internal peripheral clock level |
| rx_clk_pin | input | 1 | Receive-side external clock pin |
| tx_clk_pin | input | 1 | Transmit-side external clock pin |
| cfg_wr | input | 1 | Write strobe for divider and frame fields |
| cfg_div | input | DIV_W | Divider value, ratio is value plus one |
| cfg_fper | input | FP_W | Frame period in bit clocks, minus one |
| cfg_fwid | input | FP_W | Frame pulse width in bit clocks, minus one |
| cfg_src | input | 2 | Source select code |
| gen_en | input | 1 | Generator enable; low holds it in software reset |
| fs_en | input | 1 | Frame-sync generation enable |
| clkg | output | 1 | Divided bit clock |
| fsg | output | 1 | Frame-sync pulse |
| ready | output | 1 | Generator settled |
| src_err | output | 1 | Reserved source code selected |

## Verification
The checker watches several rules on every cycle: the half-rate toggle after device reset, the quiet outputs after a software disable, the silence and the error flag on the reserved code, and that a frame pulse or a ready rise only comes with a rising bit clock. Some behaviour can only be seen over a run, so the bench scenarios compare every output each cycle against a reference model. These are the divide ratio and duty for even, odd and unity ratios, the two-tick delay before new settings apply, the frame period and the clamped width, and the behaviour when the source changes.

// File: rtl/srg_pkg.sv
package srg_pkg;

    typedef enum logic [1:0] {
        SRC_NONE   = 2'b00,
        SRC_PERIPH = 2'b01,
        SRC_RXPIN  = 2'b10,
        SRC_TXPIN  = 2'b11
    } src_sel_e;

    localparam int unsigned N_SRC = 3;

endpackage

// File: rtl/srg_src_sync.sv
module srg_src_sync #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] tick_o
);

    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic [N-1:0] s3;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d    = q;
        d.s1 = pin_i;
        d.s2 = q.s1;
        d.s3 = q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // one edge detector per source
    for (genvar i = 0; i < N; i++) begin : g_edge
        assign lvl_o[i]  = q.s2[i];
        assign tick_o[i] = q.s2[i] & ~q.s3[i];
    end

endmodule

// File: rtl/srg_cfg_shadow.sv
module srg_cfg_shadow #(
    parameter int unsigned DIV_W = 8,
    parameter int unsigned FP_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic [FP_W-1:0]  fper_i,
    input  logic [FP_W-1:0]  fwid_i,
    input  logic             tick_i,
    output logic [DIV_W-1:0] div_o,
    output logic [FP_W-1:0]  fper_o,
    output logic [FP_W-1:0]  fwid_o
);

    typedef struct packed {
        logic [DIV_W-1:0] div_p;
        logic [FP_W-1:0]  fper_p;
        logic [FP_W-1:0]  fwid_p;
        logic             pend;
        logic             half;
        logic [DIV_W-1:0] div_a;
        logic [FP_W-1:0]  fper_a;
        logic [FP_W-1:0]  fwid_a;
    } shadow_t;

    shadow_t q, d;

    always_comb begin
        d = q;
        if (wr_i) begin
            d.div_p  = div_i;
            d.fper_p = fper_i;
            d.fwid_p = fwid_i;
            d.pend   = 1'b1;
            d.half   = 1'b0;
        end else if (q.pend && tick_i) begin
            if (q.half) begin
                d.div_a  = q.div_p;
                d.fper_a = q.fper_p;
                d.fwid_a = q.fwid_p;
                d.pend   = 1'b0;
                d.half   = 1'b0;
            end else begin
                d.half = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign div_o  = q.div_a;
    assign fper_o = q.fper_a;
    assign fwid_o = q.fwid_a;

endmodule

// File: rtl/srg_clk_div.sv
module srg_clk_div #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gen_en_i,
    input  logic             src_ok_i,
    input  logic             tick_i,
    input  logic             lvl_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             clkg_o,
    output logic             ready_o,
    output logic             err_o,
    output logic             run_o,
    output logic             rise_o
);

    localparam logic [1:0] RC_MAX = 2'd3;

    typedef struct packed {
        logic             dev;
        logic             run;
        logic [DIV_W-1:0] cnt;
        logic             clkg;
        logic [1:0]       rc;
        logic             ready;
        logic             err;
    } div_t;

    div_t q, d;
    logic             rise;
    logic [DIV_W:0]   half;

    always_comb begin
        d    = q;
        rise = 1'b0;
        half = ({1'b0, div_i} + 2'd2) >> 1;
        if (gen_en_i) d.dev = 1'b0;
        d.err = ~src_ok_i;
        if (!gen_en_i || !src_ok_i) begin
            d.run   = 1'b0;
            d.cnt   = '0;
            d.rc    = '0;
            d.ready = 1'b0;
            d.clkg  = (!gen_en_i && q.dev) ? ~q.clkg : 1'b0;
        end else begin
            if (!q.run) begin
                d.clkg = 1'b0;
                if (tick_i) begin
                    d.run  = 1'b1;
                    d.cnt  = '0;
                    d.clkg = 1'b1;
                    rise   = 1'b1;
                end
            end else begin
                if (tick_i) begin
                    d.cnt  = (q.cnt >= div_i) ? '0 : q.cnt + 1'b1;
                    rise   = (d.cnt == '0);
                    d.clkg = ({1'b0, d.cnt} < half);
                end
                if (div_i == '0) d.clkg = lvl_i;
            end
            if (rise && q.rc != RC_MAX) d.rc = q.rc + 1'b1;
            d.ready = (d.rc == RC_MAX);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.dev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign clkg_o  = q.clkg;
    assign ready_o = q.ready;
    assign err_o   = q.err;
    assign run_o   = d.run;
    assign rise_o  = rise;

endmodule

// File: rtl/srg_frame_gen.sv
module srg_frame_gen #(
    parameter int unsigned FP_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_i,
    input  logic            fs_en_i,
    input  logic            rise_i,
    input  logic [FP_W-1:0] fper_i,
    input  logic [FP_W-1:0] fwid_i,
    output logic            fsg_o
);

    typedef struct packed {
        logic [FP_W-1:0] fcnt;
        logic            armed;
        logic            fsg;
    } frm_t;

    frm_t q, d;
    logic [FP_W-1:0] wlim;

    always_comb begin
        d = q;
        if (fper_i == '0)         wlim = '0;
        else if (fwid_i >= fper_i) wlim = fper_i - 1'b1;
        else                      wlim = fwid_i;
        if (!run_i || !fs_en_i) begin
            d = '0;
        end else if (rise_i) begin
            d.fcnt  = (q.fcnt >= fper_i) ? '0 : q.fcnt + 1'b1;
            d.armed = q.armed | (d.fcnt == '0);
            d.fsg   = d.armed && (d.fcnt <= wlim);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign fsg_o = q.fsg;

endmodule

// File: rtl/srg_top.sv
module srg_top
    import srg_pkg::*;
#(
    parameter int unsigned DIV_W = 8,
    parameter int unsigned FP_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             periph_clk,
    input  logic             rx_clk_pin,
    input  logic             tx_clk_pin,
    input  logic             cfg_wr,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [FP_W-1:0]  cfg_fper,
    input  logic [FP_W-1:0]  cfg_fwid,
    input  logic [1:0]       cfg_src,
    input  logic             gen_en,
    input  logic             fs_en,
    output logic             clkg,
    output logic             fsg,
    output logic             ready,
    output logic             src_err
);

    logic [N_SRC-1:0] src_lvl;
    logic [N_SRC-1:0] src_tick;
    logic             sel_lvl;
    logic             sel_tick;
    logic             src_ok;
    logic [DIV_W-1:0] div_a;
    logic [FP_W-1:0]  fper_a;
    logic [FP_W-1:0]  fwid_a;
    logic             run_n;
    logic             rise;

    srg_src_sync #(.N(N_SRC)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  ({tx_clk_pin, rx_clk_pin, periph_clk}),
        .lvl_o  (src_lvl),
        .tick_o (src_tick)
    );

    always_comb begin
        sel_lvl  = 1'b0;
        sel_tick = 1'b0;
        src_ok   = 1'b1;
        case (src_sel_e'(cfg_src))
            SRC_PERIPH: begin sel_lvl = src_lvl[0]; sel_tick = src_tick[0]; end
            SRC_RXPIN:  begin sel_lvl = src_lvl[1]; sel_tick = src_tick[1]; end
            SRC_TXPIN:  begin sel_lvl = src_lvl[2]; sel_tick = src_tick[2]; end
            default:    src_ok = 1'b0;
        endcase
    end

    srg_cfg_shadow #(.DIV_W(DIV_W), .FP_W(FP_W)) i_shadow (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (cfg_wr),
        .div_i  (cfg_div),
        .fper_i (cfg_fper),
        .fwid_i (cfg_fwid),
        .tick_i (sel_tick),
        .div_o  (div_a),
        .fper_o (fper_a),
        .fwid_o (fwid_a)
    );

    srg_clk_div #(.DIV_W(DIV_W)) i_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .gen_en_i (gen_en),
        .src_ok_i (src_ok),
        .tick_i   (sel_tick),
        .lvl_i    (sel_lvl),
        .div_i    (div_a),
        .clkg_o   (clkg),
        .ready_o  (ready),
        .err_o    (src_err),
        .run_o    (run_n),
        .rise_o   (rise)
    );

    srg_frame_gen #(.FP_W(FP_W)) i_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run_n),
        .fs_en_i (fs_en),
        .rise_i  (rise),
        .fper_i  (fper_a),
        .fwid_i  (fwid_a),
        .fsg_o   (fsg)
    );

endmodule

// File: rtl/srg_checker.sv
module srg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cfg_src,
    input logic       gen_en,
    input logic       fs_en,
    input logic       clkg,
    input logic       fsg,
    input logic       ready,
    input logic       src_err
);

    logic seen_en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      seen_en_q <= 1'b0;
        else if (gen_en) seen_en_q <= 1'b1;
    end

    p_reserved_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_en && cfg_src == 2'b00) |=> (!clkg && !fsg));

    p_err_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_src == 2'b00) |=> src_err);

    p_err_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_src != 2'b00) |=> !src_err);

    p_dev_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!seen_en_q && !gen_en) |=> (clkg != $past(clkg)));

    p_fsg_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!gen_en) |=> !fsg);

    p_sw_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_en_q && !gen_en) |=> (!clkg && !fsg && !ready));

    p_ready_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $rose(clkg));

    p_fsg_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fsg) |-> $rose(clkg));

    p_fsg_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fsg |-> $past(fs_en));

endmodule

bind srg_top srg_checker i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_src (cfg_src),
    .gen_en  (gen_en),
    .fs_en   (fs_en),
    .clkg    (clkg),
    .fsg     (fsg),
    .ready   (ready),
    .src_err (src_err)
);

// File: tb/test_srg_top.sv
`timescale 1ns/1ps
module test_srg_top;

    localparam int DIV_W = 8;
    localparam int FP_W  = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic             rst_n = 1'b0;
    logic             periph_clk = 1'b0, rx_clk_pin = 1'b0, tx_clk_pin = 1'b0;
    logic             cfg_wr = 1'b0;
    logic [DIV_W-1:0] cfg_div = '0;
    logic [FP_W-1:0]  cfg_fper = '0;
    logic [FP_W-1:0]  cfg_fwid = '0;
    logic [1:0]       cfg_src = 2'b00;
    logic             gen_en = 1'b0, fs_en = 1'b0;
    logic             clkg, fsg, ready, src_err;

    srg_top #(.DIV_W(DIV_W), .FP_W(FP_W)) i_srg_top (
        .clk(clk), .rst_n(rst_n), .periph_clk(periph_clk),
        .rx_clk_pin(rx_clk_pin), .tx_clk_pin(tx_clk_pin),
        .cfg_wr(cfg_wr), .cfg_div(cfg_div), .cfg_fper(cfg_fper),
        .cfg_fwid(cfg_fwid), .cfg_src(cfg_src), .gen_en(gen_en),
        .fs_en(fs_en), .clkg(clkg), .fsg(fsg), .ready(ready), .src_err(src_err)
    );

    int tests = 0, fails = 0, cyc = 0;
    string tag = "R2";

    // free-running source waveforms, changed away from the sampling edge
    int pc = 0, rc = 0, xc = 0;
    always @(negedge clk) begin
        pc++; if (pc == 3) begin pc = 0; periph_clk <= ~periph_clk; end
        rc++; if (rc == 5) begin rc = 0; rx_clk_pin <= ~rx_clk_pin; end
        xc++; if (xc == 2) begin xc = 0; tx_clk_pin <= ~tx_clk_pin; end
    end

    // behavioural reference model
    int hist [1:3][0:2];
    int m_dev, m_run, m_ph, m_clkg, m_rc, m_ready, m_err, m_fc, m_arm, m_fsg;
    int p_div, p_fper, p_fwid, p_v, p_c, a_div, a_fper, a_fwid;
    int sel, tk, lv, rise, wl;

    function automatic int pin_val(int k);
        case (k)
            1: return int'(periph_clk);
            2: return int'(rx_clk_pin);
            default: return int'(tx_clk_pin);
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 1; i <= 3; i++) for (int j = 0; j < 3; j++) hist[i][j] = 0;
            m_dev = 1; m_run = 0; m_ph = 0; m_clkg = 0; m_rc = 0; m_ready = 0;
            m_err = 0; m_fc = 0; m_arm = 0; m_fsg = 0;
            p_div = 0; p_fper = 0; p_fwid = 0; p_v = 0; p_c = 0;
            a_div = 0; a_fper = 0; a_fwid = 0;
        end else begin
            sel = int'(cfg_src);
            tk = 0; lv = 0; rise = 0;
            if (sel != 0) begin
                lv = hist[sel][1];
                tk = (hist[sel][1] == 1 && hist[sel][2] == 0) ? 1 : 0;
            end
            if (!gen_en || sel == 0) begin
                m_run = 0; m_ph = 0; m_rc = 0; m_ready = 0;
                m_clkg = (!gen_en && m_dev == 1) ? 1 - m_clkg : 0;
            end else begin
                if (m_run == 0) begin
                    m_clkg = 0;
                    if (tk == 1) begin m_run = 1; m_ph = 0; m_clkg = 1; rise = 1; end
                end else begin
                    if (tk == 1) begin
                        m_ph = (m_ph >= a_div) ? 0 : m_ph + 1;
                        rise = (m_ph == 0) ? 1 : 0;
                        m_clkg = (m_ph < (a_div + 2) / 2) ? 1 : 0;
                    end
                    if (a_div == 0) m_clkg = lv;
                end
                if (rise == 1 && m_rc < 3) m_rc++;
                m_ready = (m_rc == 3) ? 1 : 0;
            end
            if (gen_en) m_dev = 0;
            m_err = (sel == 0) ? 1 : 0;
            if (m_run == 0 || !fs_en) begin
                m_fc = 0; m_arm = 0; m_fsg = 0;
            end else if (rise == 1) begin
                m_fc = (m_fc >= a_fper) ? 0 : m_fc + 1;
                if (m_fc == 0) m_arm = 1;
                wl = (a_fper == 0) ? 0 : ((a_fwid >= a_fper) ? a_fper - 1 : a_fwid);
                m_fsg = (m_arm == 1 && m_fc <= wl) ? 1 : 0;
            end
            if (cfg_wr) begin
                p_div = int'(cfg_div); p_fper = int'(cfg_fper); p_fwid = int'(cfg_fwid);
                p_v = 1; p_c = 0;
            end else if (p_v == 1 && tk == 1) begin
                if (p_c == 1) begin
                    a_div = p_div; a_fper = p_fper; a_fwid = p_fwid; p_v = 0; p_c = 0;
                end else p_c = 1;
            end
            for (int i = 1; i <= 3; i++) begin
                hist[i][2] = hist[i][1];
                hist[i][1] = hist[i][0];
                hist[i][0] = pin_val(i);
            end
        end
    end

    task automatic check1(string what, logic act, int exp);
        tests++;
        if (int'(act) != exp) begin
            fails++;
            $display("FAIL %s %s actual %0d expected %0d at cycle %0d", tag, what, act, exp, cyc);
        end
    endtask

    task automatic step(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            check1("clkg", clkg, m_clkg);
            check1("fsg", fsg, m_fsg);
            check1("ready", ready, m_ready);
            check1("src_err", src_err, m_err);
        end
    endtask

    task automatic write_cfg(int dv, int fp, int fw);
        cfg_div = DIV_W'(dv); cfg_fper = FP_W'(fp); cfg_fwid = FP_W'(fw);
        cfg_wr = 1'b1;
        step(1);
        cfg_wr = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        tag = "R2"; step(3);                       // reset state
        rst_n = 1'b1; cfg_src = 2'b01; step(20);   // half-rate toggle after device reset
        tag = "R4"; write_cfg(3, 4, 1); step(30);  // two-tick delay before apply
        tag = "R5"; gen_en = 1'b1; step(40);       // start on first source edge
        tag = "R6"; step(100);                     // even ratio of four
        tag = "R3"; gen_en = 1'b0; step(20);       // software disable keeps outputs low
        tag = "R7"; gen_en = 1'b1; step(80);       // ready after two periods
        tag = "R8"; fs_en = 1'b1; step(300);       // frame period of five bit clocks
        tag = "R9"; write_cfg(3, 4, 9); step(300); // width clamped below the period
        tag = "R8"; fs_en = 1'b0; step(30); fs_en = 1'b1; step(150);
        tag = "R6"; cfg_src = 2'b10; write_cfg(0, 3, 0); step(200); // pass-through
        tag = "R6"; cfg_src = 2'b11; write_cfg(2, 2, 1); step(200); // odd ratio
        tag = "R1"; cfg_src = 2'b00; step(50);     // reserved code
        tag = "R1"; cfg_src = 2'b01; step(80);
        tag = "R9"; write_cfg(1, 0, 3); step(120); // zero frame period
        tag = "R4"; write_cfg(4, 6, 2); step(3); write_cfg(1, 2, 0); step(150);
        tag = "R3"; gen_en = 1'b0; step(20);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule